// File: doc/BRIEF.md
# Oversampled SPI Slave Interface

This block is a byte-wide SPI slave whose logic runs entirely on the local system clock. The serial clock, select and data-in pins are treated as ordinary asynchronous inputs: each is passed through a synchroniser, and serial clock edges are found by comparing successive synchronised samples. The block follows SPI mode 0: the most significant bit comes first, data in is captured on rising serial clock edges, and data out advances on falling ones.

While select is inactive (high) the block sits idle and its data-out enable stays low, so the pad can float. During that time the host may preload the byte to be sent. Once select goes low, that byte is shifted out while a byte is shifted in. Each completed byte is copied into a holding register and raises a done flag, with an interrupt output gated by an enable input. The host can therefore read one byte while the next one arrives, and it can queue the next transmit byte before it reads. If a byte completes while the previous one is still unread, the holding register takes the new byte and a sticky overrun flag is set.

Top module: `spi_sampled_slave`

## Requirements
- R1: While the synchronised select is high, `miso_oe_o` is 0 and serial clock pulses change neither `done_o`, `rx_data_o` nor the bit position.
- R2: A byte loaded with `tx_load_i` while select is high is the byte shifted out once select goes low. Its bit 7 is on `miso_o` before the first rising serial clock edge.
- R3: `mosi_i` is captured on each rising serial clock edge, most significant bit first. `miso_o` moves to the next lower bit on each falling edge.
- R4: The eighth rising edge inside a select-low period sets `done_o` and places the byte in `rx_data_o`. A serial clock level change first sampled at clock edge k takes effect at edge k+2.
- R5: `irq_o` is 1 exactly when `done_o` is 1 and `irq_en_i` is 1.
- R6: A one-cycle `rx_read_i` pulse clears `done_o` and `overrun_o`, unless a byte completes in the same cycle. In that case `done_o` stays 1.
- R7: When a byte completes while `done_o` is 1 and no read arrives in that cycle, `overrun_o` becomes 1 and `rx_data_o` takes the new byte.
- R8: `tx_load_i` is ignored while select is low and between 1 and 7 bits of the current byte have been received.
- R9: `tx_load_i` is accepted at a byte boundary while select stays low, and the following byte sends the new value.
- R10: Raising select part-way through a byte discards that byte. `done_o` does not rise, and the next byte starts again from its first bit.
- R11: Serial clock high and low phases of 3 system clock cycles each are enough for correct transfer in both directions.
- R12: After reset `done_o`, `overrun_o`, `irq_o`, `miso_oe_o` are 0 and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| ss_n_i | input | 1 | Select, active low, asynchronous |
| mosi_i | input | 1 | Serial data in, asynchronous |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| tx_data_i | input | 8 | Byte to transmit |
| tx_load_i | input | 1 | Load pulse for `tx_data_i` |
| rx_read_i | input | 1 | Read pulse that acknowledges the held byte |
| irq_en_i | input | 1 | Interrupt enable |
| rx_data_o | output | 8 | Last received byte |
| done_o | output | 1 | Byte complete flag |
| overrun_o | output | 1 | Sticky flag for an unread byte that was overwritten |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change takes two clock edges to cross the synchroniser, so its effect on the shift registers, `done_o` and `rx_data_o` is registered at the third edge after it is first sampled. `miso_oe_o` follows select one edge sooner. `irq_o` and the effects of the host pulses appear at the first edge. The bench's reference model keeps a history of the pin values sampled at each edge and acts on the entries that are two and three edges old. Every output is compared against the model shortly after each falling clock edge, once all inputs have settled. Directed checks on captured MISO bits and held bytes, made at the end of each byte, add to those comparisons.

// File: rtl/spi_slave_pkg.sv
// Package: shared types and constants for the oversampled SPI slave.
package spi_slave_pkg;

    // Default transfer width in bits.
    localparam int unsigned SPI_WORD_W = 8;

    // Edge pulses derived from the synchronised serial clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

endpackage

// File: rtl/spi_sync.sv
// Module: spi_sync
// Brings W asynchronous inputs into the clk domain through STAGES flops each.
// Assumes: inputs are level signals held longer than STAGES clock cycles.
module spi_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
// Module: spi_edge_det
// Finds rising and falling transitions of the synchronised serial clock by
// comparing it with its value one clock earlier.
// Assumes: the input is already synchronised; each phase lasts 2+ cycles.
module spi_edge_det
    import spi_slave_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck_s,
    output sck_edge_t edge_o
);
    logic sck_prev_q;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    // Decode transitions.
    always_comb begin
        edge_o.rise = sck_s & ~sck_prev_q;
        edge_o.fall = ~sck_s & sck_prev_q;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Module: spi_shift_core
// Mode-0 shift engine: captures data in on rising edges, advances data out on
// falling edges, counts bits and flags each completed word. The transmit word
// is single-buffered: a load is refused while a word is partly shifted.
// Assumes: synchronised select and data; select high means idle.
module spi_shift_core
    import spi_slave_pkg::*;
#(
    parameter int unsigned DATA_W = SPI_WORD_W,
    localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              mosi_s,
    input  sck_edge_t         edge_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic [DATA_W-1:0] tx_hold_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic              word_done_o,
    output logic [DATA_W-1:0] rx_word_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_hold_q, tx_shift_q, rx_shift_q, hold_next;
    logic [CNT_W-1:0]  cnt_q;
    logic              mid_word, load_ok, at_last, at_bound;

    // Decide whether a host load may be taken this cycle.
    always_comb begin
        mid_word  = ~ss_s && (cnt_q != '0);
        load_ok   = tx_load_i && ~mid_word;
        hold_next = load_ok ? tx_data_i : tx_hold_q;
        at_last   = (cnt_q == LAST_BIT);
        at_bound  = (cnt_q == '0);
    end

    // Transmit holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_hold_q <= '0;
        else        tx_hold_q <= hold_next;
    end

    // Transmit shifter: reloads when idle or at a boundary, shifts on falls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_shift_q <= '0;
        else if (ss_s || (at_bound && (edge_i.fall || load_ok)))
            tx_shift_q <= hold_next;
        else if (edge_i.fall)
            tx_shift_q <= {tx_shift_q[DATA_W-2:0], 1'b0};
    end

    // Bit position within the word; cleared whenever select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_s)
            cnt_q <= '0;
        else if (edge_i.rise)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    // Receive shifter.
    always_ff @(posedge clk) begin
        if (!rst_n)           rx_shift_q <= '0;
        else if (edge_i.rise) rx_shift_q <= {rx_shift_q[DATA_W-2:0], mosi_s};
    end

    // Word completion and outputs.
    always_comb begin
        word_done_o = ~ss_s && edge_i.rise && at_last;
        rx_word_o   = {rx_shift_q[DATA_W-2:0], mosi_s};
        miso_o      = tx_shift_q[DATA_W-1];
        tx_hold_o   = tx_hold_q;
        bit_cnt_o   = cnt_q;
    end
endmodule

// File: rtl/spi_rx_buffer.sv
// Module: spi_rx_buffer
// Holds the last received word, the done flag and the sticky overrun flag.
// Assumes: word_done_i is a one-cycle pulse; rx_read_i is a one-cycle pulse.
module spi_rx_buffer #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              rx_read_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              overrun_o
);
    logic [DATA_W-1:0] data_q;
    logic              done_q, ovr_q;

    // Capture words and manage the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (word_done_i) begin
            data_q <= rx_word_i;
            done_q <= 1'b1;
            if (done_q && !rx_read_i) ovr_q <= 1'b1;
            else if (rx_read_i)       ovr_q <= 1'b0;
        end else if (rx_read_i) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end
    end

    assign rx_data_o = data_q;
    assign done_o    = done_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/spi_sampled_slave.sv
// Module: spi_sampled_slave (top)
// SPI mode-0 slave clocked by the system clock: synchronises the pins, detects
// serial clock edges, shifts words both ways and buffers received words.
// Assumes: serial clock phases each last more than 2 system clock cycles.
module spi_sampled_slave
    import spi_slave_pkg::*;
#(
    parameter int unsigned DATA_W      = SPI_WORD_W,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    input  logic              rx_read_i,
    input  logic              irq_en_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              overrun_o,
    output logic              irq_o
);
    logic [2:0]        pins_sync;
    logic              sck_sync, ss_sync, mosi_sync;
    sck_edge_t         sck_edge;
    logic [DATA_W-1:0] tx_hold, rx_word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              word_done;

    // Pin order in the bundle: {select, serial clock, data in}.
    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ss_n_i, sck_i, mosi_i}),
        .sync_o(pins_sync)
    );

    assign {ss_sync, sck_sync, mosi_sync} = pins_sync;

    spi_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_sync), .edge_o(sck_edge)
    );

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ss_s(ss_sync), .mosi_s(mosi_sync), .edge_i(sck_edge),
        .tx_data_i(tx_data_i), .tx_load_i(tx_load_i),
        .miso_o(miso_o), .tx_hold_o(tx_hold), .bit_cnt_o(bit_cnt),
        .word_done_o(word_done), .rx_word_o(rx_word)
    );

    spi_rx_buffer #(.DATA_W(DATA_W)) u_rxbuf (
        .clk(clk), .rst_n(rst_n),
        .word_done_i(word_done), .rx_word_i(rx_word), .rx_read_i(rx_read_i),
        .rx_data_o(rx_data_o), .done_o(done_o), .overrun_o(overrun_o)
    );

    // Drive the pad only while selected; gate the interrupt.
    always_comb begin
        miso_oe_o = ~ss_sync;
        irq_o     = done_o & irq_en_i;
    end
endmodule

// File: rtl/spi_slave_checker.sv
// Module: spi_slave_checker
// Temporal properties of spi_sampled_slave, attached with bind below.
module spi_slave_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n_i,
    input logic              miso_oe_o,
    input logic              tx_load_i,
    input logic              rx_read_i,
    input logic              irq_en_i,
    input logic              done_o,
    input logic              overrun_o,
    input logic              irq_o,
    input logic              ss_sync,
    input logic              word_done,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] tx_hold
);
    assert_idle_tristate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ss_n_i, 2) |-> !miso_oe_o);

    assert_idle_no_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sync |-> !word_done);

    assert_done_follows_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> done_o);

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> irq_en_i);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read_i && !word_done) |=> (!done_o && !overrun_o));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && done_o && !rx_read_i) |=> overrun_o);

    assert_load_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_sync && bit_cnt != '0 && tx_load_i) |=> $stable(tx_hold));
endmodule

bind spi_sampled_slave spi_slave_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n_i), .miso_oe_o(miso_oe_o),
    .tx_load_i(tx_load_i), .rx_read_i(rx_read_i), .irq_en_i(irq_en_i),
    .done_o(done_o), .overrun_o(overrun_o), .irq_o(irq_o),
    .ss_sync(ss_sync), .word_done(word_done), .bit_cnt(bit_cnt), .tx_hold(tx_hold)
);

// File: tb/test_spi_sampled_slave.sv
`timescale 1ns/1ps
module test_spi_sampled_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic       miso_o, miso_oe_o;
    logic [7:0] tx_data_i = 8'h00;
    logic       tx_load_i = 1'b0, rx_read_i = 1'b0, irq_en_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       done_o, overrun_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    spi_sampled_slave i_spi_sampled_slave (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .tx_data_i(tx_data_i),
        .tx_load_i(tx_load_i), .rx_read_i(rx_read_i), .irq_en_i(irq_en_i),
        .rx_data_o(rx_data_o), .done_o(done_o), .overrun_o(overrun_o), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    // Pin history: index 0 = value at this edge, 1 = one edge before, ...
    bit [3:0] h_sck, h_ss, h_mosi;
    bit [7:0] m_hold, m_txs, m_rxs, m_rx;
    int       m_cnt;
    bit       m_done, m_ovr;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_sck = '0; h_ss = '1; h_mosi = '0;
            m_hold = 0; m_txs = 0; m_rxs = 0; m_rx = 0;
            m_cnt = 0; m_done = 0; m_ovr = 0;
        end else begin
            bit ss, rise, fall, ok, fin;
            bit [7:0] hn, word;
            h_sck  = {h_sck[2:0], sck_i};
            h_ss   = {h_ss[2:0], ss_n_i};
            h_mosi = {h_mosi[2:0], mosi_i};
            ss   = h_ss[2];
            rise = h_sck[2] && !h_sck[3];
            fall = !h_sck[2] && h_sck[3];
            ok   = tx_load_i && !(!ss && m_cnt != 0);
            hn   = ok ? tx_data_i : m_hold;
            fin  = !ss && rise && m_cnt == 7;
            word = {m_rxs[6:0], h_mosi[2]};
            if (ss || (m_cnt == 0 && (fall || ok))) m_txs = hn;
            else if (fall) m_txs = m_txs << 1;
            m_hold = hn;
            if (rise) m_rxs = word;
            if (ss) m_cnt = 0;
            else if (rise) m_cnt = (m_cnt + 1) % 8;
            if (fin) begin
                m_rx = word;
                if (m_done && !rx_read_i) m_ovr = 1;
                else if (rx_read_i) m_ovr = 0;
                m_done = 1;
            end else if (rx_read_i) begin
                m_done = 0; m_ovr = 0;
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle after the inputs of the falling edge have settled.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            check("R1", "miso_oe", miso_oe_o, !h_ss[1]);
            check("R4", "done", done_o, m_done);
            check("R4", "rx_data", rx_data_o, m_rx);
            check("R7", "overrun", overrun_o, m_ovr);
            check("R5", "irq", irq_o, m_done && irq_en_i);
            if (!h_ss[1]) check("R3", "miso", miso_o, m_txs[7]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_load(input logic [7:0] v);
        @(negedge clk); tx_data_i = v; tx_load_i = 1'b1;
        @(negedge clk); tx_load_i = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_read_i = 1'b1;
        @(negedge clk); rx_read_i = 1'b0;
    endtask

    task automatic set_ss(input logic v);
        @(negedge clk); ss_n_i = v;
        wait_clk(4);
    endtask

    // Master side of a mode-0 transfer of nbits; optional load at one bit.
    task automatic xfer(input logic [7:0] mo, input int nbits, input int ph,
                        input int load_bit, input logic [7:0] load_val,
                        output logic [7:0] mi);
        mi = '0;
        for (int b = 7; b > 7 - nbits; b--) begin
            @(negedge clk); mosi_i = mo[b];
            if (7 - b == load_bit) host_load(load_val);
            else wait_clk(2);
            wait_clk(ph - 2);
            mi[b] = miso_o;
            sck_i = 1'b1;
            wait_clk(ph);
            sck_i = 1'b0;
        end
        wait_clk(ph);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] mi;
        wait_clk(4);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R12: reset state
        check("R12", "done", done_o, 0);
        check("R12", "overrun", overrun_o, 0);
        check("R12", "irq", irq_o, 0);
        check("R12", "miso_oe", miso_oe_o, 0);
        check("R12", "rx_data", rx_data_o, 0);

        // R1: pulses while select high are ignored
        xfer(8'hFF, 8, 4, -1, 8'h00, mi);
        check("R1", "done after idle clocks", done_o, 0);
        check("R1", "miso_oe idle", miso_oe_o, 0);

        // R2/R3/R4/R5: preload while idle, one full byte
        irq_en_i = 1'b1;
        host_load(8'hA5);
        set_ss(1'b0);
        check("R2", "first bit before clocks", miso_o, 1);
        xfer(8'h3C, 8, 4, -1, 8'h00, mi);
        check("R2", "byte seen by master", mi, 8'hA5);
        check("R3", "byte received", rx_data_o, 8'h3C);
        check("R4", "done set", done_o, 1);
        check("R5", "irq with enable", irq_o, 1);
        irq_en_i = 1'b0;
        @(negedge clk); #1;
        check("R5", "irq masked", irq_o, 0);

        // R9: load next at boundary, then read
        host_load(8'h5A);
        host_read();
        check("R6", "done cleared by read", done_o, 0);
        xfer(8'hC3, 8, 4, -1, 8'h00, mi);
        check("R9", "boundary load sent", mi, 8'h5A);
        host_read();

        // R8: load attempted after bit 3 is ignored
        xfer(8'h81, 8, 4, 3, 8'hFF, mi);
        check("R8", "mid-byte load ignored this byte", mi, 8'h5A);
        xfer(8'h18, 8, 4, -1, 8'h00, mi);
        check("R8", "hold unchanged next byte", mi, 8'h5A);
        check("R7", "overrun after unread byte", overrun_o, 1);
        check("R7", "newer byte kept", rx_data_o, 8'h18);
        host_read();
        check("R6", "overrun cleared", overrun_o, 0);
        set_ss(1'b1);

        // R10: abort after 3 bits
        host_load(8'h96);
        set_ss(1'b0);
        xfer(8'hE0, 3, 4, -1, 8'h00, mi);
        set_ss(1'b1);
        check("R10", "no done on abort", done_o, 0);
        set_ss(1'b0);
        xfer(8'h6B, 8, 4, -1, 8'h00, mi);
        check("R10", "restart from bit 0 rx", rx_data_o, 8'h6B);
        check("R10", "restart from bit 0 tx", mi, 8'h96);
        host_read();
        set_ss(1'b1);

        // R11: three-cycle phases
        host_load(8'h4D);
        set_ss(1'b0);
        xfer(8'hB2, 8, 3, -1, 8'h00, mi);
        check("R11", "fast rx", rx_data_o, 8'hB2);
        check("R11", "fast tx", mi, 8'h4D);
        set_ss(1'b1);
        wait_clk(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule